// File: doc/BRIEF.md
# Parallel IO Pin Controller Bank

The block controls one bank of 32 IO pins through a small word-addressed register interface. Each pin has six attributes: who owns it (the GPIO logic or a peripheral), which of two peripheral functions drives it when GPIO does not own it, the GPIO output enable, the GPIO output data, the pull-up enable and open-drain mode. Every attribute is changed through a pair of write-only offsets, one that sets and one that clears. The write data is a mask, so software can change any group of pins in one write and never needs a read-modify-write. A third offset in each group returns the current attribute vector.

For each pin the pad driver takes its value and enable from the GPIO registers or from peripheral function A or B. Open-drain mode then turns the result into a drive-low or release pattern. The pull-up enable is passed straight to the pad. The pad input levels pass through a two-stage synchronizer and can be read at their own offset at any time, whatever the pin's owner.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is owned by GPIO (ownership status reads 0xFFFFFFFF), peripheral A is selected, output enable, output data and open-drain status read 0, and pull-up status reads 0xFFFFFFFF. So padOe is 0 and padPullEn is all ones.
- R2: A write to offset 0 gives the pins whose mask bit is 1 to GPIO. A write to offset 1 hands them to a peripheral. Offset 2 reads the ownership vector (1 = GPIO).
- R3: A write to offset 3 selects peripheral B for the masked pins and a write to offset 4 selects peripheral A. Offset 5 reads the selection vector (1 = B). A pin not owned by GPIO takes its value and enable from the selected peripheral's inputs.
- R4: Offsets 6 and 7 set and clear the GPIO output enable and offset 8 reads it. On a GPIO-owned pin without open-drain, padOe equals this bit.
- R5: Offsets 9 and 10 set and clear the GPIO output data and offset 11 reads it. On a GPIO-owned pin without open-drain, padOut equals this bit.
- R6: Offsets 12 and 13 set and clear the pull-up enable and offset 14 reads it. padPullEn equals the pull-up vector for every pin, whatever its owner.
- R7: Offsets 15 and 16 set and clear open-drain mode and offset 17 reads it. For a pin in this mode, padOut is 0 and padOe is 1 only when the pin is enabled and its value is 0. This applies to both GPIO and peripheral drive.
- R8: Offset 18 reads the pad input levels of all pins as they stood two clock edges before the edge that captures the read, whatever each pin's owner.
- R9: Read data appears on busRdata on the edge after the read request and is 0 in every other cycle. Set and clear offsets, and offsets 19 to 31, read as 0. Writes to status offsets, to offset 18 and to offsets 19 to 31 change no state.
- R10: A set or clear write changes only the bits whose mask bit is 1. A mask of zero changes nothing, and the new value is in effect from the edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Word offset of the access |
| busWdata | input | 32 | Write mask / data |
| busRdata | output | 32 | Registered read data |
| periphAOut | input | 32 | Peripheral function A output values |
| periphAOe | input | 32 | Peripheral function A output enables |
| periphBOut | input | 32 | Peripheral function B output values |
| periphBOe | input | 32 | Peripheral function B output enables |
| padIn | input | 32 | Asynchronous pad input levels |
| padOut | output | 32 | Pad output value |
| padOe | output | 32 | Pad output enable |
| padPullEn | output | 32 | Pad pull-up enable |

## Verification
The hardest case to reach from the ports is a pin that is both handed to a peripheral and in open-drain mode while the selected peripheral's value and enable toggle. In that case four register bits and two live inputs combine on the same pad. The bench sets up mixed masks so that pins in every combination of owner, selection and open-drain sit side by side. It then re-randomises both peripheral input sets on every cycle while a behavioural model predicts each pad bit. The synchronizer lag is checked by changing padIn every cycle during a burst of back-to-back level reads. Each value is then checked again by hand after a quiet period.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NUM_ATTR   = 6;
  localparam int ADDR_W     = 5;
  localparam int SLOT_W     = 3;               // set, clear, status per attribute
  localparam int LEVEL_ADDR = NUM_ATTR * SLOT_W;

  localparam int ATTR_OWN  = 0;  // 1 = GPIO owns the pin
  localparam int ATTR_SEL  = 1;  // 1 = peripheral B
  localparam int ATTR_OE   = 2;
  localparam int ATTR_DATA = 3;
  localparam int ATTR_PU   = 4;
  localparam int ATTR_OD   = 5;

  typedef struct packed {
    logic [NUM_ATTR-1:0] setStb;
    logic [NUM_ATTR-1:0] clrStb;
    logic [NUM_ATTR-1:0] rdAttr;
    logic                rdLevel;
    logic                rdStb;
  } pio_strobe_t;

  function automatic logic attrResetBit(int attr);
    return (attr == ATTR_OWN) || (attr == ATTR_PU);
  endfunction
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output pio_strobe_t       strobe
);

  always_comb begin
    strobe = '0;
    strobe.rdStb   = busSel && !busWrite;
    strobe.rdLevel = busSel && !busWrite && (busAddr == ADDR_W'(LEVEL_ADDR));
    for (int a = 0; a < NUM_ATTR; a++) begin
      if (busSel && busWrite && (busAddr == ADDR_W'(a * SLOT_W)))
        strobe.setStb[a] = 1'b1;
      if (busSel && busWrite && (busAddr == ADDR_W'(a * SLOT_W + 1)))
        strobe.clrStb[a] = 1'b1;
      if (busSel && !busWrite && (busAddr == ADDR_W'(a * SLOT_W + 2)))
        strobe.rdAttr[a] = 1'b1;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setStb, strobe.clrStb, strobe.rdAttr, strobe.rdLevel})); // R9

  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite) |-> (strobe.rdAttr == '0 && !strobe.rdLevel && !strobe.rdStb)); // R9

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (strobe == '0)); // R10

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  pio_strobe_t     strobe,
  input  logic [PINS-1:0] busWdata,
  output logic [PINS-1:0] busRdata,
  input  logic [PINS-1:0] periphAOut,
  input  logic [PINS-1:0] periphAOe,
  input  logic [PINS-1:0] periphBOut,
  input  logic [PINS-1:0] periphBOe,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic [PINS-1:0] padPullEn
);

  logic [NUM_ATTR-1:0][PINS-1:0] attrVec;

  // One set/clear register per attribute
  for (genvar a = 0; a < NUM_ATTR; a++) begin : gAttr
    logic [PINS-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  q <= {PINS{attrResetBit(a)}};
      else if (strobe.setStb[a])  q <= q | busWdata;
      else if (strobe.clrStb[a])  q <= q & ~busWdata;
    end
    assign attrVec[a] = q;

    AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setStb[a] |=> ((attrVec[a] & $past(busWdata)) == $past(busWdata))); // R10

    AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrStb[a] |=> ((attrVec[a] & $past(busWdata)) == '0)); // R10

    AST_MASK_ONLY: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.setStb[a] || strobe.clrStb[a]) |=>
        (((attrVec[a] ^ $past(attrVec[a])) & ~$past(busWdata)) == '0)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.setStb[a] || strobe.clrStb[a]) |=> $stable(attrVec[a])); // R9
  end

  // Per-pin owner mux and open-drain shaping
  for (genvar i = 0; i < PINS; i++) begin : gPin
    logic selVal, selEn, drvVal, drvEn;
    always_comb begin
      selVal = attrVec[ATTR_SEL][i] ? periphBOut[i] : periphAOut[i];
      selEn  = attrVec[ATTR_SEL][i] ? periphBOe[i]  : periphAOe[i];
      drvVal = attrVec[ATTR_OWN][i] ? attrVec[ATTR_DATA][i] : selVal;
      drvEn  = attrVec[ATTR_OWN][i] ? attrVec[ATTR_OE][i]   : selEn;
      if (attrVec[ATTR_OD][i]) begin
        padOut[i] = 1'b0;
        padOe[i]  = drvEn & ~drvVal;
      end else begin
        padOut[i] = drvVal;
        padOe[i]  = drvEn;
      end
    end
  end

  assign padPullEn = attrVec[ATTR_PU];

  // Two-flop pad input synchronizer
  logic [PINS-1:0] syncA, syncB;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // Registered read mux
  logic [PINS-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (strobe.rdLevel) rdMux = syncB;
    for (int a = 0; a < NUM_ATTR; a++)
      if (strobe.rdAttr[a]) rdMux = rdMux | attrVec[a];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busRdata <= '0;
    else if (strobe.rdStb)  busRdata <= rdMux;
    else                    busRdata <= '0;
  end

  // Checker state: edges seen since reset, saturating at 2
  logic [1:0] edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               edgeCnt <= '0;
    else if (edgeCnt != 2'd2) edgeCnt <= edgeCnt + 2'd1;
  end

  AST_LEVEL_LAG: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == 2'd2) |-> (syncB == $past(padIn, 2))); // R8

  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdStb |=> (busRdata == '0)); // R9

  AST_OD_NO_HIGH_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & padOut & attrVec[ATTR_OD]) == '0)); // R7

  AST_PULL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setStb[ATTR_PU] |=> ((padPullEn & $past(busWdata)) == $past(busWdata))); // R6

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  input  logic [PINS-1:0]   periphAOut,
  input  logic [PINS-1:0]   periphAOe,
  input  logic [PINS-1:0]   periphBOut,
  input  logic [PINS-1:0]   periphBOe,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padPullEn
);

  pio_strobe_t strobe;

  pio_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  pio_datapath #(.PINS(PINS)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .periphAOut (periphAOut),
    .periphAOe  (periphAOe),
    .periphBOut (periphBOut),
    .periphBOe  (periphBOe),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .padPullEn  (padPullEn)
  );

endmodule

// File: tb/pio_bank_tb.sv
`timescale 1ns/1ps
module pio_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] periphAOut = '0, periphAOe = '0, periphBOut = '0, periphBOe = '0;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe, padPullEn;

  always #2.5 clk = ~clk;   // 200 MHz

  pio_bank dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .periphAOut(periphAOut), .periphAOe(periphAOe),
    .periphBOut(periphBOut), .periphBOe(periphBOe),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn)
  );

  int    vectors = 0;
  int    misses  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  bit    randPeriph = 0;
  string curTag  = "R1";

  // Behavioural model: index 0 own,1 selB,2 oe,3 data,4 pull,5 opendrain
  logic [31:0] mReg [6];
  logic [31:0] mS1, mS2, mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg[0] = '1; mReg[1] = '0; mReg[2] = '0;
      mReg[3] = '0; mReg[4] = '1; mReg[5] = '0;
      mS1 = '0; mS2 = '0; mRd = '0;
    end else begin
      mRd = '0;
      if (busSel && !busWrite) begin
        if (busAddr == 5'd18) mRd = mS2;
        else if (busAddr < 5'd18 && (busAddr % 3) == 2) mRd = mReg[busAddr / 3];
      end
      if (busSel && busWrite && busAddr < 5'd18) begin
        if ((busAddr % 3) == 0) mReg[busAddr / 3] = mReg[busAddr / 3] | busWdata;
        else if ((busAddr % 3) == 1) mReg[busAddr / 3] = mReg[busAddr / 3] & ~busWdata;
      end
      mS2 = mS1;
      mS1 = padIn;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s act=%h exp=%h", curTag, what, act, exp);
    end
  endtask

  // Per-cycle comparison of every output against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [31:0] eOut, eOe, v, e;
      for (int i = 0; i < 32; i++) begin
        v[i] = mReg[0][i] ? mReg[3][i] : (mReg[1][i] ? periphBOut[i] : periphAOut[i]);
        e[i] = mReg[0][i] ? mReg[2][i] : (mReg[1][i] ? periphBOe[i]  : periphAOe[i]);
        eOut[i] = mReg[5][i] ? 1'b0 : v[i];
        eOe[i]  = mReg[5][i] ? (e[i] & ~v[i]) : e[i];
      end
      chk("padOut", padOut, eOut);
      chk("padOe", padOe, eOe);
      chk("padPullEn", padPullEn, mReg[4]);
      chk("busRdata", busRdata, mRd);
    end
  end

  // Peripheral input scrambler
  initial begin
    forever begin
      @(posedge clk); #1;
      if (randPeriph) begin
        periphAOut = $urandom; periphAOe = $urandom;
        periphBOut = $urandom; periphBOe = $urandom;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic rdExpect(logic [4:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    busSel = 1; busWrite = 0; busAddr = a;
    @(posedge clk); #1;
    busSel = 0;
    @(negedge clk);
    chk("readback", busRdata, exp);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1: reset state
    curTag = "R1";
    @(negedge clk);
    chk("padOe reset", padOe, 32'h0);
    chk("padPullEn reset", padPullEn, 32'hFFFF_FFFF);
    rdExpect(5'd2,  32'hFFFF_FFFF);
    rdExpect(5'd5,  32'h0);
    rdExpect(5'd8,  32'h0);
    rdExpect(5'd11, 32'h0);
    rdExpect(5'd14, 32'hFFFF_FFFF);
    rdExpect(5'd17, 32'h0);

    // R4 / R5: GPIO output on owned pins
    curTag = "R4";
    wr(5'd6, 32'h0000_FFFF);
    rdExpect(5'd8, 32'h0000_FFFF);
    curTag = "R5";
    wr(5'd9, 32'h00FF_00FF);
    rdExpect(5'd11, 32'h00FF_00FF);
    @(negedge clk);
    chk("padOut gpio", padOut, 32'h00FF_00FF);
    wr(5'd10, 32'h0000_000F);
    rdExpect(5'd11, 32'h00FF_00F0);
    curTag = "R4";
    wr(5'd7, 32'h0000_0F00);
    @(negedge clk);
    chk("padOe gpio", padOe, 32'h0000_F0FF);

    // R2 / R3: hand pins to peripherals with mixed selection
    randPeriph = 1;
    curTag = "R2";
    wr(5'd1, 32'hF0F0_F0F0);
    rdExpect(5'd2, 32'h0F0F_0F0F);
    curTag = "R3";
    wr(5'd3, 32'hCCCC_CCCC);
    rdExpect(5'd5, 32'hCCCC_CCCC);
    idle(20);
    wr(5'd4, 32'h4444_0000);
    rdExpect(5'd5, 32'h8888_CCCC);
    idle(20);
    curTag = "R2";
    wr(5'd0, 32'h3000_0000);
    rdExpect(5'd2, 32'h3F0F_0F0F);
    idle(10);

    // R7: open drain on a mix of owners
    curTag = "R7";
    wr(5'd15, 32'hAAAA_AAAA);
    rdExpect(5'd17, 32'hAAAA_AAAA);
    idle(40);
    wr(5'd16, 32'h0000_AAAA);
    rdExpect(5'd17, 32'hAAAA_0000);
    idle(20);

    // R6: pull-up control
    curTag = "R6";
    wr(5'd13, 32'h1234_5678);
    rdExpect(5'd14, 32'hEDCB_A987);
    @(negedge clk);
    chk("padPullEn", padPullEn, 32'hEDCB_A987);
    wr(5'd12, 32'h0000_0007);
    rdExpect(5'd14, 32'hEDCB_A987);

    // R8: pad level through synchronizer, independent of owner
    curTag = "R8";
    @(posedge clk); #1 padIn = 32'hDEAD_BEEF;
    idle(3);
    rdExpect(5'd18, 32'hDEAD_BEEF);
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); #1;
      padIn = $urandom; busSel = 1; busWrite = 0; busAddr = 5'd18;
    end
    @(posedge clk); #1 busSel = 0;
    padIn = 32'h5A5A_0001;
    idle(3);
    rdExpect(5'd18, 32'h5A5A_0001);

    // R9: unmapped and read-only offsets
    curTag = "R9";
    rdExpect(5'd0, 32'h0);
    rdExpect(5'd19, 32'h0);
    rdExpect(5'd31, 32'h0);
    wr(5'd2, 32'hFFFF_FFFF);
    wr(5'd18, 32'hFFFF_FFFF);
    wr(5'd25, 32'hFFFF_FFFF);
    rdExpect(5'd2, 32'h3F0F_0F0F);
    rdExpect(5'd17, 32'hAAAA_0000);

    // R10: zero mask, then random traffic on every offset
    curTag = "R10";
    wr(5'd9, 32'h0);
    wr(5'd10, 32'h0);
    rdExpect(5'd11, 32'h00FF_00F0);
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      busSel = ($urandom % 4) != 0;
      busWrite = $urandom % 2;
      busAddr = $urandom % 32;
      busWdata = $urandom;
      padIn = $urandom;
    end
    @(posedge clk); #1 busSel = 0;
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule